// File: doc/BRIEF.md
# Level/Edge Interrupt Dispatcher with Storm Throttle

This block keeps the request state of a bank of interrupt input lines and turns it into delivery requests for a downstream interrupt fabric. Each line has a configuration entry supplied from an external register file. The entry gives the mask bit, the trigger mode, the vector, the destination, the destination mode and the delivery kind. Line activity arrives as one-cycle raise and drop strobes. End-of-interrupt (EOI) broadcasts arrive with a vector, a trigger mode and a directed-EOI flag. The block answers with one request at a time on a valid/ready handshake. It also sends per-line set and clear commands for the remote-IRR bits, which the register file stores and returns on `rirr_in`.

Edge-mode lines fire once per assertion. Level-mode lines fire again after each matching EOI while the line stays requested. A line whose EOIs keep re-firing it without a break is treated as a storm. The block counts these back-to-back EOI re-firings per line. On the count that reaches `STORM_LIMIT`, it does not re-fire the line at once. It starts a shared timer of `DEFER_CYCLES` clocks instead, and when that timer expires it sweeps all level-mode lines once.

Top module: `irq_level_edge_dispatch`

## Requirements
- R1: A drop strobe clears the line's request bit. After a drop, neither a later entry rewrite nor a timer sweep produces a delivery for that line.
- R2: In edge mode (`ent_level`=0), a raise while the line's request bit is already set is merged with the earlier one and produces no new request. A raise after a drop produces a new request.
- R3: No request is issued for a line whose `ent_mask` bit is 1, or for a line in level mode (`ent_level`=1) whose remote-IRR bit is set.
- R4: When a level-mode request is accepted (`dlv_ready`=1) with `dlv_hit`=1, `rirr_set` pulses that line's bit in the same cycle. No set command is made for an edge-mode request or for an accept with `dlv_hit`=0.
- R5: A level-mode EOI that is not directed clears the remote-IRR bit of every level-mode line whose vector matches. If such a line is unmasked and its request bit is still set, it is requested again.
- R6: An EOI with `eoi_level`=0 or `eoi_directed`=1 produces no `rirr_clr` command and no new request.
- R7: Each line counts its back-to-back EOI re-requests. The EOI that would bring the count to `STORM_LIMIT` resets the count to zero and starts the deferral timer instead of requesting the line.
- R8: A matching level-mode EOI that finds the line masked or its request bit clear resets that line's count to zero.
- R9: When the deferral timer expires, `DEFER_CYCLES` clocks after it was started, every level-mode line whose request bit is set and whose remote-IRR bit is clear is requested. No line is requested by the timer earlier than that.
- R10: A rewrite strobe (`ent_wr`) for a level-mode line whose request bit is set causes a service attempt for that line.
- R11: When several lines are ready, the lowest-numbered one is issued first, one request per accept. `dlv_valid` and the request fields stay unchanged until they are accepted.
- R12: After reset no request is pending and no remote-IRR command is active. A request carries the line number and that line's vector, destination, destination mode, delivery kind and trigger mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_raise | input | N_PINS | Per-line assertion strobe |
| line_drop | input | N_PINS | Per-line deassertion strobe; wins over a raise in the same cycle |
| ent_mask | input | N_PINS | Entry mask bits, 1 = masked |
| ent_level | input | N_PINS | Entry trigger mode, 1 = level, 0 = edge |
| ent_vector | input | N_PINS*VEC_W | Entry vectors, line i at bits [i*VEC_W +: VEC_W] |
| ent_dest | input | N_PINS*DEST_W | Entry destinations |
| ent_dest_mode | input | N_PINS | Entry destination modes |
| ent_kind | input | N_PINS*KIND_W | Entry delivery kinds |
| ent_wr | input | 1 | Strobe: the entry selected by ent_wr_pin was rewritten |
| ent_wr_pin | input | PIN_W | Line number of the rewritten entry |
| rirr_in | input | N_PINS | Remote-IRR bits as stored in the register file |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | VEC_W | Vector of the EOI |
| eoi_level | input | 1 | Trigger mode of the EOI, 1 = level |
| eoi_directed | input | 1 | Receiver is in directed-EOI mode |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Delivery request accepted this cycle |
| dlv_hit | input | 1 | At least one destination took the accepted request |
| dlv_pin | output | PIN_W | Line number of the request |
| dlv_vector | output | VEC_W | Vector of the request |
| dlv_dest | output | DEST_W | Destination of the request |
| dlv_dest_mode | output | 1 | Destination mode of the request |
| dlv_kind | output | KIND_W | Delivery kind of the request |
| dlv_level | output | 1 | Trigger mode of the request |
| rirr_set | output | N_PINS | One-cycle remote-IRR set commands |
| rirr_clr | output | N_PINS | One-cycle remote-IRR clear commands |

## Verification
The bound checker tests these properties on every cycle:
- a request stays steady until it is accepted;
- a newly issued request never has a lower-numbered line that was also ready;
- a request never comes from a line that was masked or blocked by remote IRR;
- remote-IRR set and clear commands appear only under the handshake or EOI conditions that allow them;
- starting the deferral timer always leaves it running.

Some behaviour depends on history and can only be shown by the bench's scenarios:
- merging of edge raises;
- the exact EOI count at which throttling starts;
- the count being reset by a masked EOI;
- the timer sweep arriving within its window;
- a rewrite starting a delivery.

// File: rtl/irq_dlv_pkg.sv
package irq_dlv_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  // True when one more back-to-back re-service reaches the storm limit.
  function automatic logic storm_trips(input logic [31:0] cnt, input logic [31:0] limit);
    return (cnt + 32'd1) == limit;
  endfunction

  // Next value of a storm counter after a re-service attempt.
  function automatic logic [31:0] storm_step(input logic [31:0] cnt, input logic [31:0] limit);
    return ((cnt + 32'd1) == limit) ? 32'd0 : (cnt + 32'd1);
  endfunction

endpackage

// File: rtl/irq_line_state.sv
module irq_line_state #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raise,
  input  logic [N-1:0] drop,
  input  logic [N-1:0] trig_level,
  output logic [N-1:0] irr,
  output logic [N-1:0] line_svc,
  output logic [N-1:0] coalesce
);
  logic [N-1:0] irr_q;
  logic [N-1:0] eff_raise;

  always_comb begin
    eff_raise = raise & ~drop;
    coalesce  = eff_raise & ~trig_level & irr_q;
    line_svc  = eff_raise & ~coalesce;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irr_q <= '0;
    else        irr_q <= (irr_q & ~drop) | eff_raise;
  end

  assign irr = irr_q;
endmodule

// File: rtl/irq_eoi_throttle.sv
module irq_eoi_throttle
  import irq_dlv_pkg::*;
#(
  parameter int N     = 24,
  parameter int VW    = 8,
  parameter int LIMIT = 10000,
  parameter int DEFER = 1000000,
  localparam int CW   = $clog2(LIMIT + 1),
  localparam int TW   = $clog2(DEFER + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eoi_valid,
  input  logic [VW-1:0]   eoi_vec,
  input  logic            eoi_level,
  input  logic            eoi_directed,
  input  logic [N*VW-1:0] cfg_vector,
  input  logic [N-1:0]    trig_level,
  input  logic [N-1:0]    mask,
  input  logic [N-1:0]    irr,
  input  logic [N-1:0]    rirr_in,
  output logic [N-1:0]    rirr_clr,
  output logic [N-1:0]    eoi_svc,
  output logic [N-1:0]    timer_svc,
  output logic            defer_arm,
  output logic            defer_busy
);
  logic [N-1:0]  arm_vec;
  logic [TW-1:0] timer_q;
  logic          expire;
  logic          reload;

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic          acts;
    logic          ready;
    logic          trips;
    logic [CW-1:0] cnt_q;

    assign acts  = eoi_valid && (eoi_level == TRIG_LEVEL) && !eoi_directed &&
                   trig_level[g] && (cfg_vector[g*VW +: VW] == eoi_vec);
    assign ready = acts && !mask[g] && irr[g];
    assign trips = ready && storm_trips(32'(cnt_q), 32'(LIMIT));

    always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (ready) cnt_q <= CW'(storm_step(32'(cnt_q), 32'(LIMIT)));
      else if (acts)  cnt_q <= '0;
    end

    assign rirr_clr[g] = acts;
    assign eoi_svc[g]  = ready && !trips;
    assign arm_vec[g]  = trips;
  end

  assign defer_arm  = |arm_vec;
  assign defer_busy = (timer_q != '0);
  assign expire     = (timer_q == TW'(1));
  assign reload     = defer_arm && (!defer_busy || expire);
  assign timer_svc  = expire ? (trig_level & irr & ~rirr_in) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)          timer_q <= '0;
    else if (reload)     timer_q <= TW'(DEFER);
    else if (defer_busy) timer_q <= timer_q - TW'(1);
  end
endmodule

// File: rtl/irq_issue_arb.sv
module irq_issue_arb #(
  parameter int N  = 24,
  parameter int PW = 5,
  parameter int VW = 8,
  parameter int DW = 8,
  parameter int KW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    svc_req,
  input  logic [N-1:0]    mask,
  input  logic [N-1:0]    trig_level,
  input  logic [N-1:0]    rirr_in,
  input  logic [N*VW-1:0] cfg_vector,
  input  logic [N*DW-1:0] cfg_dest,
  input  logic [N-1:0]    cfg_dest_mode,
  input  logic [N*KW-1:0] cfg_kind,
  input  logic            out_ready,
  input  logic            out_hit,
  output logic            out_valid,
  output logic [PW-1:0]   out_pin,
  output logic [VW-1:0]   out_vector,
  output logic [DW-1:0]   out_dest,
  output logic            out_dest_mode,
  output logic [KW-1:0]   out_kind,
  output logic            out_level,
  output logic [N-1:0]    rirr_set,
  output logic [N-1:0]    eligible
);
  function automatic logic [PW-1:0] lowest_idx(input logic [N-1:0] v);
    logic [PW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = PW'(i);
    return r;
  endfunction

  logic [N-1:0]  pend_q, pend_d, grant_vec;
  logic          load, accept;
  logic [PW-1:0] pick;
  logic [VW-1:0] sel_vec;
  logic [DW-1:0] sel_dest;
  logic [KW-1:0] sel_kind;
  logic          valid_q, dmode_q, level_q;
  logic [PW-1:0] pin_q;
  logic [VW-1:0] vec_q;
  logic [DW-1:0] dest_q;
  logic [KW-1:0] kind_q;

  always_comb begin
    eligible  = pend_q & ~mask & ~(trig_level & rirr_in);
    pick      = lowest_idx(eligible);
    load      = !valid_q && (|eligible);
    accept    = valid_q && out_ready;
    grant_vec = load ? (N'(1) << pick) : '0;
    pend_d    = (pend_q & eligible & ~grant_vec) | svc_req;
    sel_vec   = cfg_vector[int'(pick)*VW +: VW];
    sel_dest  = cfg_dest[int'(pick)*DW +: DW];
    sel_kind  = cfg_kind[int'(pick)*KW +: KW];
    rirr_set  = (accept && level_q && out_hit) ? (N'(1) << pin_q) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      valid_q <= 1'b0;
      pin_q   <= '0;
      vec_q   <= '0;
      dest_q  <= '0;
      dmode_q <= 1'b0;
      kind_q  <= '0;
      level_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (load) begin
        valid_q <= 1'b1;
        pin_q   <= pick;
        vec_q   <= sel_vec;
        dest_q  <= sel_dest;
        dmode_q <= cfg_dest_mode[pick];
        kind_q  <= sel_kind;
        level_q <= trig_level[pick];
      end else if (accept) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign out_valid     = valid_q;
  assign out_pin       = pin_q;
  assign out_vector    = vec_q;
  assign out_dest      = dest_q;
  assign out_dest_mode = dmode_q;
  assign out_kind      = kind_q;
  assign out_level     = level_q;
endmodule

// File: rtl/irq_level_edge_dispatch.sv
module irq_level_edge_dispatch #(
  parameter int N_PINS       = 24,
  parameter int VEC_W        = 8,
  parameter int DEST_W       = 8,
  parameter int KIND_W       = 3,
  parameter int STORM_LIMIT  = 10000,
  parameter int DEFER_CYCLES = 1000000,
  localparam int PIN_W       = $clog2(N_PINS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_PINS-1:0]        line_raise,
  input  logic [N_PINS-1:0]        line_drop,
  input  logic [N_PINS-1:0]        ent_mask,
  input  logic [N_PINS-1:0]        ent_level,
  input  logic [N_PINS*VEC_W-1:0]  ent_vector,
  input  logic [N_PINS*DEST_W-1:0] ent_dest,
  input  logic [N_PINS-1:0]        ent_dest_mode,
  input  logic [N_PINS*KIND_W-1:0] ent_kind,
  input  logic                     ent_wr,
  input  logic [PIN_W-1:0]         ent_wr_pin,
  input  logic [N_PINS-1:0]        rirr_in,
  input  logic                     eoi_valid,
  input  logic [VEC_W-1:0]         eoi_vector,
  input  logic                     eoi_level,
  input  logic                     eoi_directed,
  output logic                     dlv_valid,
  input  logic                     dlv_ready,
  input  logic                     dlv_hit,
  output logic [PIN_W-1:0]         dlv_pin,
  output logic [VEC_W-1:0]         dlv_vector,
  output logic [DEST_W-1:0]        dlv_dest,
  output logic                     dlv_dest_mode,
  output logic [KIND_W-1:0]        dlv_kind,
  output logic                     dlv_level,
  output logic [N_PINS-1:0]        rirr_set,
  output logic [N_PINS-1:0]        rirr_clr
);
  logic [N_PINS-1:0] irr_w, line_svc_w, coalesce_w;
  logic [N_PINS-1:0] eoi_svc_w, timer_svc_w, wr_svc_w, svc_all_w, elig_w;
  logic              defer_arm_w, defer_busy_w;

  irq_line_state #(.N(N_PINS)) u_lines (
    .clk(clk), .rst_n(rst_n), .raise(line_raise), .drop(line_drop),
    .trig_level(ent_level), .irr(irr_w), .line_svc(line_svc_w), .coalesce(coalesce_w)
  );

  irq_eoi_throttle #(
    .N(N_PINS), .VW(VEC_W), .LIMIT(STORM_LIMIT), .DEFER(DEFER_CYCLES)
  ) u_throttle (
    .clk(clk), .rst_n(rst_n), .eoi_valid(eoi_valid), .eoi_vec(eoi_vector),
    .eoi_level(eoi_level), .eoi_directed(eoi_directed), .cfg_vector(ent_vector),
    .trig_level(ent_level), .mask(ent_mask), .irr(irr_w), .rirr_in(rirr_in),
    .rirr_clr(rirr_clr), .eoi_svc(eoi_svc_w), .timer_svc(timer_svc_w),
    .defer_arm(defer_arm_w), .defer_busy(defer_busy_w)
  );

  assign wr_svc_w  = (ent_wr ? (N_PINS'(1) << ent_wr_pin) : '0) & ent_level & irr_w;
  assign svc_all_w = line_svc_w | eoi_svc_w | timer_svc_w | wr_svc_w;

  irq_issue_arb #(
    .N(N_PINS), .PW(PIN_W), .VW(VEC_W), .DW(DEST_W), .KW(KIND_W)
  ) u_arb (
    .clk(clk), .rst_n(rst_n), .svc_req(svc_all_w), .mask(ent_mask),
    .trig_level(ent_level), .rirr_in(rirr_in), .cfg_vector(ent_vector),
    .cfg_dest(ent_dest), .cfg_dest_mode(ent_dest_mode), .cfg_kind(ent_kind),
    .out_ready(dlv_ready), .out_hit(dlv_hit), .out_valid(dlv_valid),
    .out_pin(dlv_pin), .out_vector(dlv_vector), .out_dest(dlv_dest),
    .out_dest_mode(dlv_dest_mode), .out_kind(dlv_kind), .out_level(dlv_level),
    .rirr_set(rirr_set), .eligible(elig_w)
  );
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int N  = 24,
  parameter int PW = 5,
  parameter int VW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dlv_valid,
  input logic          dlv_ready,
  input logic          dlv_hit,
  input logic          dlv_level,
  input logic [PW-1:0] dlv_pin,
  input logic [VW-1:0] dlv_vector,
  input logic [DW-1:0] dlv_dest,
  input logic [N-1:0]  rirr_set,
  input logic [N-1:0]  rirr_clr,
  input logic [N-1:0]  rirr_in,
  input logic [N-1:0]  ent_mask,
  input logic          eoi_valid,
  input logic          eoi_level,
  input logic          eoi_directed,
  input logic [N-1:0]  eligible,
  input logic          defer_arm,
  input logic          defer_busy
);
  logic [N-1:0] elig_q, mask_q, rirr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elig_q <= '0;
      mask_q <= '0;
      rirr_q <= '0;
    end else begin
      elig_q <= eligible;
      mask_q <= ent_mask;
      rirr_q <= rirr_in;
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_pin) && $stable(dlv_vector) && $stable(dlv_dest));

  assert_lowest_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlv_valid) |-> ((elig_q & ((N'(1) << dlv_pin) - N'(1))) == '0));

  assert_no_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlv_valid) |-> !mask_q[dlv_pin] && !(dlv_level && rirr_q[dlv_pin]));

  assert_rset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr_set != '0) |-> dlv_valid && dlv_ready && dlv_hit && dlv_level && $onehot0(rirr_set));

  assert_rclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr_clr != '0) |-> eoi_valid && eoi_level && !eoi_directed);

  assert_timer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    defer_arm |=> defer_busy);
endmodule

bind irq_level_edge_dispatch irq_dispatch_chk #(
  .N(N_PINS), .PW(PIN_W), .VW(VEC_W), .DW(DEST_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
  .dlv_hit(dlv_hit), .dlv_level(dlv_level), .dlv_pin(dlv_pin),
  .dlv_vector(dlv_vector), .dlv_dest(dlv_dest), .rirr_set(rirr_set),
  .rirr_clr(rirr_clr), .rirr_in(rirr_in), .ent_mask(ent_mask),
  .eoi_valid(eoi_valid), .eoi_level(eoi_level), .eoi_directed(eoi_directed),
  .eligible(elig_w), .defer_arm(defer_arm_w), .defer_busy(defer_busy_w)
);

// File: tb/irq_level_edge_dispatch_tb.sv
module irq_level_edge_dispatch_tb;
  localparam int N = 24, VW = 8, DW = 8, KW = 3, PW = 5, LIM = 4, DEF = 40;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [N-1:0] line_raise, line_drop, ent_mask, ent_level, ent_dest_mode;
  logic [N*VW-1:0] ent_vector;
  logic [N*DW-1:0] ent_dest;
  logic [N*KW-1:0] ent_kind;
  logic ent_wr;
  logic [PW-1:0] ent_wr_pin;
  logic [N-1:0] rirr_model;
  logic eoi_valid, eoi_level, eoi_directed;
  logic [VW-1:0] eoi_vector;
  logic dlv_valid, dlv_ready, dlv_hit, dlv_dest_mode, dlv_level;
  logic [PW-1:0] dlv_pin;
  logic [VW-1:0] dlv_vector;
  logic [DW-1:0] dlv_dest;
  logic [KW-1:0] dlv_kind;
  logic [N-1:0] rirr_set, rirr_clr;

  int errors = 0, checks = 0;
  bit done = 0;

  irq_level_edge_dispatch #(
    .N_PINS(N), .VEC_W(VW), .DEST_W(DW), .KIND_W(KW),
    .STORM_LIMIT(LIM), .DEFER_CYCLES(DEF)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .line_raise(line_raise), .line_drop(line_drop),
    .ent_mask(ent_mask), .ent_level(ent_level), .ent_vector(ent_vector),
    .ent_dest(ent_dest), .ent_dest_mode(ent_dest_mode), .ent_kind(ent_kind),
    .ent_wr(ent_wr), .ent_wr_pin(ent_wr_pin), .rirr_in(rirr_model),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level),
    .eoi_directed(eoi_directed), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
    .dlv_hit(dlv_hit), .dlv_pin(dlv_pin), .dlv_vector(dlv_vector),
    .dlv_dest(dlv_dest), .dlv_dest_mode(dlv_dest_mode), .dlv_kind(dlv_kind),
    .dlv_level(dlv_level), .rirr_set(rirr_set), .rirr_clr(rirr_clr)
  );

  // Register-file model of the remote-IRR bits.
  always_ff @(posedge clk) begin
    if (!rst_n) rirr_model <= '0;
    else        rirr_model <= (rirr_model | rirr_set) & ~rirr_clr;
  end

  // Stimulus table: {expect_request, mask, level, pin[4:0], vector[7:0]}
  localparam logic [15:0] TBL [0:4] = '{
    {1'b1, 1'b0, 1'b0, 5'd0,  8'h30},
    {1'b1, 1'b0, 1'b1, 5'd5,  8'h41},
    {1'b0, 1'b1, 1'b0, 5'd23, 8'h52},
    {1'b0, 1'b1, 1'b1, 5'd12, 8'h63},
    {1'b1, 1'b0, 1'b1, 5'd7,  8'h74}
  };

  localparam int P3 = 3;
  localparam logic [VW-1:0] V3 = 8'h9C;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic raise(int p);
    line_raise[p] = 1'b1; tick(1); line_raise[p] = 1'b0;
  endtask

  task automatic drop(int p);
    line_drop[p] = 1'b1; tick(1); line_drop[p] = 1'b0;
  endtask

  task automatic accept(logic hit, logic [N-1:0] exp_set, string req);
    dlv_ready = 1'b1; dlv_hit = hit;
    #1 check(req, 32'(rirr_set), 32'(exp_set));
    tick(1);
    dlv_ready = 1'b0; dlv_hit = 1'b0;
    check(req, 32'(dlv_valid), 32'd0);
  endtask

  task automatic eoi(logic [VW-1:0] v, logic lvl, logic dir, logic [N-1:0] exp_clr, string req);
    eoi_valid = 1'b1; eoi_vector = v; eoi_level = lvl; eoi_directed = dir;
    #1 check(req, 32'(rirr_clr), 32'(exp_clr));
    tick(1);
    eoi_valid = 1'b0;
  endtask

  // EOI on line 3 that must re-request it at once, followed by an accept.
  task automatic eoi_immediate(string req);
    eoi(V3, 1'b1, 1'b0, N'(1) << P3, req);
    tick(1);
    check(req, 32'(dlv_valid), 32'd1);
    check(req, 32'(dlv_pin), P3);
    accept(1'b1, N'(1) << P3, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    line_raise = '0; line_drop = '0; ent_mask = '1; ent_level = '0;
    ent_dest = '0; ent_dest_mode = '0; ent_kind = '0;
    ent_wr = 1'b0; ent_wr_pin = '0;
    eoi_valid = 1'b0; eoi_vector = '0; eoi_level = 1'b0; eoi_directed = 1'b0;
    dlv_ready = 1'b0; dlv_hit = 1'b0;
    for (int i = 0; i < N; i++) ent_vector[i*VW +: VW] = 8'(8'h20 + i);
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R12 reset valid", 32'(dlv_valid), 32'd0);
    check("R12 reset set", 32'(rirr_set), 32'd0);
    check("R12 reset clr", 32'(rirr_clr), 32'd0);

    // Table walk: main delivery and mask gating (R3, R12).
    for (int r = 0; r < 5; r++) begin
      int p;
      p = int'(TBL[r][12:8]);
      ent_mask[p] = TBL[r][14];
      ent_level[p] = TBL[r][13];
      ent_vector[p*VW +: VW] = TBL[r][7:0];
      raise(p);
      tick(1);
      check("R3/R12 table valid", 32'(dlv_valid), 32'(TBL[r][15]));
      if (TBL[r][15]) begin
        check("R12 table pin", 32'(dlv_pin), 32'(p));
        check("R12 table vector", 32'(dlv_vector), 32'(TBL[r][7:0]));
        check("R12 table level", 32'(dlv_level), 32'(TBL[r][13]));
        accept(1'b0, '0, "R4 no hit no set");
      end
      drop(p);
      ent_mask[p] = 1'b1;
    end

    // Line 3, level mode: full field check and remote-IRR set (R12, R4).
    ent_mask[P3] = 1'b0; ent_level[P3] = 1'b1; ent_vector[P3*VW +: VW] = V3;
    ent_dest[P3*DW +: DW] = 8'hA5; ent_dest_mode[P3] = 1'b1; ent_kind[P3*KW +: KW] = 3'b101;
    raise(P3); tick(1);
    check("R12 valid", 32'(dlv_valid), 32'd1);
    check("R12 dest", 32'(dlv_dest), 32'hA5);
    check("R12 dest mode", 32'(dlv_dest_mode), 32'd1);
    check("R12 kind", 32'(dlv_kind), 32'd5);
    accept(1'b1, N'(1) << P3, "R4 level set");
    check("R4 rirr stored", 32'(rirr_model[P3]), 32'd1);

    raise(P3); tick(1);
    check("R3 blocked by rirr", 32'(dlv_valid), 32'd0);

    eoi(V3, 1'b0, 1'b0, '0, "R6 edge eoi");
    eoi(V3, 1'b1, 1'b1, '0, "R6 directed eoi");
    tick(1);
    check("R6 no request", 32'(dlv_valid), 32'd0);
    check("R6 rirr kept", 32'(rirr_model[P3]), 32'd1);

    eoi(V3, 1'b1, 1'b0, N'(1) << P3, "R5 eoi clear");
    check("R5 rirr cleared", 32'(rirr_model[P3]), 32'd0);
    tick(1);
    check("R5 re-request", 32'(dlv_valid), 32'd1);
    check("R5 re-request pin", 32'(dlv_pin), P3);
    accept(1'b1, N'(1) << P3, "R5 accept");

    // Count is 1; two more immediate, then the limit defers (R7, R9).
    eoi_immediate("R7 count2");
    eoi_immediate("R7 count3");
    eoi(V3, 1'b1, 1'b0, N'(1) << P3, "R7 trip");
    tick(1);
    check("R7 deferred", 32'(dlv_valid), 32'd0);
    tick(29);
    check("R9 not early", 32'(dlv_valid), 32'd0);
    tick(15);
    check("R9 sweep delivered", 32'(dlv_valid), 32'd1);
    check("R9 sweep pin", 32'(dlv_pin), P3);
    accept(1'b1, N'(1) << P3, "R9 accept");

    // Counter cleared by a masked EOI (R8), rewrite service (R10).
    eoi_immediate("R7 after reset 1");
    eoi_immediate("R7 after reset 2");
    ent_mask[P3] = 1'b1;
    eoi(V3, 1'b1, 1'b0, N'(1) << P3, "R8 masked eoi");
    tick(1);
    check("R8 masked no request", 32'(dlv_valid), 32'd0);
    ent_mask[P3] = 1'b0;
    ent_wr = 1'b1; ent_wr_pin = PW'(P3); tick(1); ent_wr = 1'b0;
    tick(1);
    check("R10 rewrite request", 32'(dlv_valid), 32'd1);
    accept(1'b1, N'(1) << P3, "R10 accept");
    eoi_immediate("R8 count1");
    eoi_immediate("R8 count2");
    eoi_immediate("R8 count3");
    eoi(V3, 1'b1, 1'b0, N'(1) << P3, "R7 second trip");
    tick(1);
    check("R7 second deferred", 32'(dlv_valid), 32'd0);

    // Drop before the sweep: nothing may be delivered (R1).
    drop(P3);
    tick(60);
    check("R1 no sweep after drop", 32'(dlv_valid), 32'd0);
    ent_wr = 1'b1; ent_wr_pin = PW'(P3); tick(1); ent_wr = 1'b0;
    tick(2);
    check("R1 no rewrite service", 32'(dlv_valid), 32'd0);
    ent_mask[P3] = 1'b1;

    // Edge merge (R2).
    ent_mask[10] = 1'b0; ent_level[10] = 1'b0;
    raise(10); tick(1);
    check("R2 first edge", 32'(dlv_valid), 32'd1);
    accept(1'b1, '0, "R4 edge no set");
    raise(10); tick(2);
    check("R2 merged", 32'(dlv_valid), 32'd0);
    drop(10); raise(10); tick(1);
    check("R2 after drop", 32'(dlv_valid), 32'd1);
    accept(1'b0, '0, "R2 accept");
    drop(10);

    // Lowest-first ordering and hold (R11).
    ent_mask[15] = 1'b0; ent_mask[9] = 1'b0; ent_mask[20] = 1'b0;
    line_raise[15] = 1'b1; line_raise[9] = 1'b1; line_raise[20] = 1'b1;
    tick(1);
    line_raise = '0;
    tick(1);
    check("R11 first pin", 32'(dlv_pin), 32'd9);
    tick(2);
    check("R11 held valid", 32'(dlv_valid), 32'd1);
    check("R11 held pin", 32'(dlv_pin), 32'd9);
    accept(1'b0, '0, "R11 accept 9");
    tick(1);
    check("R11 second pin", 32'(dlv_pin), 32'd15);
    accept(1'b0, '0, "R11 accept 15");
    tick(1);
    check("R11 third pin", 32'(dlv_pin), 32'd20);
    accept(1'b0, '0, "R11 accept 20");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule